// File: doc/BRIEF.md
# Hardware/Software Event Bridge

This block moves single events between a hardware datapath and a processor through a small word-addressed register port. In the inbound direction a one-cycle hardware event, together with its data word, is captured into a one-place holding register and flagged as pending. Software then either polls the pending flag or takes an interrupt, reads the captured data, and clears the flag by writing a one to an acknowledge bit. If a second event arrives before the first has been acknowledged, the held data is replaced by the newer data and the flag stays set.

In the outbound direction software first writes a data word and then raises a strobe bit. The strobe is a plain register bit, so it stays high for as long as software leaves it set. An edge detector turns each low-to-high change of that bit into exactly one single-cycle hardware event. The data word is presented alongside the event in the same cycle.

Top module: `evt_bridge`

## Requirements
- R1: After reset the pending flag, the interrupt enable, the interrupt output, the outbound event and all four registers read as zero.
- R2: An inbound event (`hw_evt_i` high for one cycle) sets the pending flag (bit 0 at byte offset 0x0) and stores `hw_evt_data_i` at offset 0x4. Both are readable after the next clock edge.
- R3: An inbound event that arrives while the flag is already pending replaces the stored data with the new data, and the flag remains set.
- R4: A write to offset 0x0 with bit 1 set clears the pending flag. A write to offset 0x0 with bit 1 clear leaves the flag unchanged.
- R5: When an inbound event and an acknowledge write land in the same cycle, the event wins: the flag stays set and holds the new data.
- R6: With the interrupt enable (bit 2 at offset 0x0, read/write) set, `irq_o` is high while the flag is pending and stays high until the flag is acknowledged.
- R7: With the interrupt enable clear, `irq_o` stays low even while an event is pending (polled mode).
- R8: Each rising edge of the strobe bit (bit 0 at offset 0xC, read/write) produces exactly one `sw_evt_o` pulse lasting one cycle, however long the bit stays high. Rewriting the bit to one while it is already one produces no pulse.
- R9: While `sw_evt_o` is high, `sw_evt_data_o` carries the word that was last written to offset 0x8.
- R10: Offsets 0x8 and 0xC read back the last value written to them. Addresses at 0x10 and above read as zero, and writes to them change no register.
- R11: Read data appears on `rdata_o` the cycle after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| hw_evt_i | input | 1 | Inbound hardware event pulse |
| hw_evt_data_i | input | DATA_W | Data carried by the inbound event |
| irq_o | output | 1 | Interrupt request, level |
| sw_evt_o | output | 1 | Outbound single-cycle event |
| sw_evt_data_o | output | DATA_W | Data carried by the outbound event |

## Verification
The hardest case to reach is an inbound event that lands in the same clock as an acknowledge write. That collision decides whether an event is silently lost. The bench drives the event input and the register write together on one negative edge, so both are sampled by the same rising edge. It then checks that the interrupt is still raised and that the new data can be read back. Long and repeated strobe writes are also driven, so the bench can confirm that a level held for several cycles yields one pulse only.

// File: rtl/evt_bridge_pkg.sv
package evt_bridge_pkg;
  localparam int unsigned BIT_PEND = 0;
  localparam int unsigned BIT_ACK  = 1;
  localparam int unsigned BIT_IEN  = 2;

  // word index taken from addr[3:2]
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_H2S  = 2'd1,
    REG_S2H  = 2'd2,
    REG_STB  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_bridge_in.sv
module evt_bridge_in #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [DATA_W-1:0] evt_data_i,
  input  logic              ack_i,
  output logic              pending_o,
  output logic [DATA_W-1:0] value_o
);
  logic              pending_q;
  logic [DATA_W-1:0] value_q;

  // a new event has priority over a concurrent acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      value_q   <= '0;
    end else if (evt_i) begin
      pending_q <= 1'b1;
      value_q   <= evt_data_i;
    end else if (ack_i) begin
      pending_q <= 1'b0;
    end
  end

  assign pending_o = pending_q;
  assign value_o   = value_q;

  p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (pending_o && value_o == $past(evt_data_i)));
  p_ack_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !evt_i) |=> !pending_o);
  p_race_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && evt_i) |=> pending_o);
  p_pend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !ack_i) |=> pending_o);
endmodule

// File: rtl/evt_bridge_out.sv
module evt_bridge_out #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              evt_o,
  output logic [DATA_W-1:0] evt_data_o
);
  logic stb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_d_q <= 1'b0;
    else         stb_d_q <= stb_i;
  end

  assign evt_o      = stb_i & ~stb_d_q;
  assign evt_data_o = val_i;

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  p_pulse_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i) |=> (evt_o == stb_i));
endmodule

// File: rtl/evt_bridge_regs.sv
module evt_bridge_regs
  import evt_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] h2s_val_i,
  output logic              ack_o,
  output logic              irq_en_o,
  output logic [DATA_W-1:0] s2h_val_o,
  output logic              s2h_stb_o
);
  localparam int unsigned HI_W = ADDR_W - 4;

  reg_sel_e          sel;
  logic              mapped;
  logic              wr, rd;
  logic              irq_en_q, stb_q;
  logic [DATA_W-1:0] s2h_q, rdata_q, rd_mux;

  assign sel    = reg_sel_e'(addr_i[3:2]);
  assign mapped = (addr_i[ADDR_W-1:4] == HI_W'(0));
  assign wr     = req_i & we_i & mapped;
  assign rd     = req_i & ~we_i;
  assign ack_o  = wr && (sel == REG_CTRL) && wdata_i[BIT_ACK];

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      unique case (sel)
        REG_CTRL: begin
          rd_mux[BIT_PEND] = pending_i;
          rd_mux[BIT_IEN]  = irq_en_q;
        end
        REG_H2S: rd_mux    = h2s_val_i;
        REG_S2H: rd_mux    = s2h_q;
        REG_STB: rd_mux[0] = stb_q;
        default: rd_mux    = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      s2h_q    <= '0;
      stb_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr) begin
        unique case (sel)
          REG_CTRL: irq_en_q <= wdata_i[BIT_IEN];
          REG_S2H:  s2h_q    <= wdata_i;
          REG_STB:  stb_q    <= wdata_i[0];
          default:  ;
        endcase
      end
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o   = rdata_q;
  assign irq_en_o  = irq_en_q;
  assign s2h_val_o = s2h_q;
  assign s2h_stb_o = stb_q;

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  p_unmapped_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !mapped) |=> ($stable(s2h_val_o) && $stable(s2h_stb_o) && $stable(irq_en_o)));
endmodule

// File: rtl/evt_bridge.sv
module evt_bridge #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              hw_evt_i,
  input  logic [DATA_W-1:0] hw_evt_data_i,
  output logic              irq_o,
  output logic              sw_evt_o,
  output logic [DATA_W-1:0] sw_evt_data_o
);
  logic              pending, ack, irq_en, stb;
  logic [DATA_W-1:0] h2s_val, s2h_val;

  evt_bridge_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pending_i (pending),
    .h2s_val_i (h2s_val),
    .ack_o     (ack),
    .irq_en_o  (irq_en),
    .s2h_val_o (s2h_val),
    .s2h_stb_o (stb)
  );

  evt_bridge_in #(.DATA_W(DATA_W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (hw_evt_i),
    .evt_data_i (hw_evt_data_i),
    .ack_i      (ack),
    .pending_o  (pending),
    .value_o    (h2s_val)
  );

  evt_bridge_out #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .val_i      (s2h_val),
    .evt_o      (sw_evt_o),
    .evt_data_o (sw_evt_data_o)
  );

  assign irq_o = pending & irq_en;

  p_polled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en && !(req_i && we_i)) |=> (!irq_o || irq_en));
endmodule

// File: tb/evt_bridge_bench.sv
module evt_bridge_bench;
  localparam int DW = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          hw_evt = 1'b0;
  logic [DW-1:0] hw_data = '0;
  logic          irq, sw_evt;
  logic [DW-1:0] sw_data;

  int n_chk = 0, n_fail = 0;
  int pulse_cnt = 0;
  logic [DW-1:0] last_pulse = '0;
  logic rd_fire = 1'b0;
  logic done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  evt_bridge #(.DATA_W(DW), .ADDR_W(AW)) u_evt_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hw_evt_i(hw_evt), .hw_evt_data_i(hw_data),
    .irq_o(irq), .sw_evt_o(sw_evt), .sw_evt_data_o(sw_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against scoreboard
  always @(posedge clk) rd_fire <= req && !we;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 1, 0);
      else check(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
    if (sw_evt) begin
      pulse_cnt++;
      last_pulse = sw_data;
    end
  end

  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic fire(logic [DW-1:0] d);
    hw_evt = 1; hw_data = d;
    @(negedge clk);
    hw_evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 sw_evt", sw_evt, 0);
    bus_rd(0, 0, "R1 ctrl");
    bus_rd(4, 0, "R1 h2s");
    bus_rd(8, 0, "R1 s2h");
    bus_rd(12, 0, "R1 stb");

    fire(16'h1234);
    check("R7 polled irq", irq, 0);
    bus_rd(0, 16'h0001, "R2 pending");
    bus_rd(4, 16'h1234, "R2 value");
    fire(16'hBEEF);
    bus_rd(4, 16'hBEEF, "R3 overwrite");
    bus_rd(0, 16'h0001, "R3 still pending");
    check("R7 polled irq", irq, 0);

    bus_wr(0, 16'h0000);
    bus_rd(0, 16'h0001, "R4 no ack bit");
    bus_wr(0, 16'h0002);
    bus_rd(0, 16'h0000, "R4 acked");

    bus_wr(0, 16'h0004);
    check("R6 idle irq", irq, 0);
    bus_rd(0, 16'h0004, "R6 ien readback");
    fire(16'h0042);
    check("R6 irq raised", irq, 1);
    repeat (5) @(negedge clk);
    check("R6 irq held", irq, 1);
    bus_wr(0, 16'h0006);
    check("R6 irq cleared", irq, 0);

    // event and ack in the same cycle
    hw_evt = 1; hw_data = 16'h0077;
    req = 1; we = 1; addr = 0; wdata = 16'h0006;
    @(negedge clk);
    hw_evt = 0; req = 0; we = 0;
    check("R5 irq after race", irq, 1);
    bus_rd(4, 16'h0077, "R5 value after race");
    bus_wr(0, 16'h0006);
    check("R5 later ack", irq, 0);

    bus_wr(8, 16'hA5A5);
    bus_rd(8, 16'hA5A5, "R10 s2h readback");
    bus_wr(12, 16'h0001);
    repeat (5) @(negedge clk);
    bus_rd(12, 16'h0001, "R10 stb readback");
    bus_wr(12, 16'h0000);
    check("R8 one pulse held", pulse_cnt, 1);
    check("R9 pulse data", 32'(last_pulse), 32'h0000A5A5);

    bus_wr(8, 16'h0F0F);
    bus_wr(12, 16'h0001);
    bus_wr(12, 16'h0001);
    bus_wr(12, 16'h0000);
    check("R8 rewrite no pulse", pulse_cnt, 2);
    check("R9 pulse data 2", 32'(last_pulse), 32'h00000F0F);

    bus_wr(5'h10, 16'hFFFF);
    bus_wr(5'h18, 16'hFFFF);
    bus_rd(5'h10, 16'h0000, "R10 unmapped read");
    bus_rd(0, 16'h0004, "R10 ctrl untouched");
    bus_rd(8, 16'h0F0F, "R10 s2h untouched");
    repeat (3) @(negedge clk);
    check("R11 rdata hold", 32'(rdata), 32'h00000F0F);
    check("R10 no stray pulse", pulse_cnt, 2);
    check("R11 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule